// File: doc/BRIEF.md
# Per-Plane Blink Buffer Switcher

This block picks, frame by frame, which of two start addresses a single display plane scans out from. In ordinary operation it behaves as a double-buffer selector: software sets a select bit, and the block adopts that bit at the next vertical sync, so the plane never changes buffer in the middle of a frame. When the 2-bit mode input holds the blink code, the block ignores the select bit. It then alternates between the two buffers by itself, keeping buffer 0 for a programmable number of frames and buffer 1 for another programmable number.

A frame counter inside the block sets the dwell time in blink mode. Each dwell length is taken from its period input at the moment the block switches into that buffer. A period written while a dwell is running therefore applies from the next dwell of that buffer. A period of zero is treated as one frame. The block reports the chosen start address and the buffer-select bit. It also raises a one-cycle strobe in the cycle the selection changes, so downstream fetch logic can reload its address.

Top module: `blink_buf_switch`

## Requirements
- R1: While reset is held and right after it, buf_sel_o is 0, switch_o is 0 and start_addr_o equals addr0_i.
- R2: With mode_i not equal to binary 10, each vsync_i pulse loads sw_sel_i into buf_sel_o. The new value is visible in the cycle after the pulse.
- R3: buf_sel_o changes only in the cycle after a vsync_i pulse. Changes to mode_i, sw_sel_i or the periods between pulses have no effect on it.
- R4: start_addr_o equals addr1_i when buf_sel_o is 1 and addr0_i when buf_sel_o is 0.
- R5: A vsync_i pulse that finds mode_i equal to binary 10 after a pulse that did not starts blink operation. buf_sel_o becomes 0, the frame counter becomes zero, and that frame is the first of the buffer-0 dwell.
- R6: In blink mode buffer 0 is held for per_a_i frames and buffer 1 for per_b_i frames, alternating. A frame is one vsync_i interval.
- R7: A period input of 0 gives the same one-frame dwell as a value of 1.
- R8: switch_o is high for exactly the one cycle in which buf_sel_o takes a new value, and low at all other times.
- R9: Each dwell length is read at the switch into that buffer (at blink entry for buffer 0). A period changed during a dwell does not shorten or lengthen that dwell.
- R10: A vsync_i pulse with mode_i not equal to binary 10 ends blink operation, and buf_sel_o returns to following sw_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | One-cycle pulse at each frame boundary |
| mode_i | input | 2 | Buffer mode; binary 10 selects blink |
| per_a_i | input | PW (8) | Frames to hold buffer 0 in blink mode |
| per_b_i | input | PW (8) | Frames to hold buffer 1 in blink mode |
| sw_sel_i | input | 1 | Software buffer select used outside blink mode |
| addr0_i | input | AW (32) | Start address of buffer 0 |
| addr1_i | input | AW (32) | Start address of buffer 1 |
| start_addr_o | output | AW (32) | Start address of the selected buffer |
| buf_sel_o | output | 1 | Selected buffer |
| switch_o | output | 1 | One-cycle strobe when the selection changes |

## Verification
The main function is driven through three kinds of pattern. The first is a plain select-bit sequence in two non-blink mode codes, which separates "follows software" from "follows blink". The second is a blink run with unequal periods of 2 and 3, which shows whether the two dwells are counted against the right period and off by none. The third is a run with both periods at zero, which shows whether zero is handled as one frame rather than as a wrap to 256. A period rewritten partway through a dwell, a blink entry that begins on buffer 1, and mode or select changes between sync pulses separate read-at-switch from read-continuously, and frame-boundary updates from immediate ones.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;
   localparam int unsigned BSW_MODE_W = 2;
   localparam logic [BSW_MODE_W-1:0] BSW_MODE_BLINK = 2'b10;

   typedef enum logic [1:0] {
      BSW_EV_NONE  = 2'd0,
      BSW_EV_ENTER = 2'd1,
      BSW_EV_TICK  = 2'd2,
      BSW_EV_SOFT  = 2'd3
   } bsw_event_e;
endpackage

// File: rtl/bsw_period_sel.sv
`timescale 1ns/1ps
module bsw_period_sel #(
   parameter int unsigned PW = 8
) (
   input  logic [PW-1:0] per_a_i,
   input  logic [PW-1:0] per_b_i,
   input  logic          pick_b_i,
   output logic [PW-1:0] dwell_o
);
   localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

   logic [PW-1:0] raw;

   always_comb begin
      raw = pick_b_i ? per_b_i : per_a_i;
      // R7: a zero period is taken as a one-frame dwell
      dwell_o = (raw == '0) ? ONE : raw;
   end
endmodule

// File: rtl/bsw_dwell_counter.sv
`timescale 1ns/1ps
module bsw_dwell_counter #(
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          tick_i,
   input  logic [PW-1:0] load_i,
   output logic          hit_o
);
   localparam int unsigned CW = PW + 1;
   localparam logic [CW-1:0] INC = {{(CW-1){1'b0}}, 1'b1};

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] dwell_q;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = {1'b0, cnt_q} + INC;
      hit_o   = tick_i && (cnt_nxt == {1'b0, dwell_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         dwell_q <= {{(PW-1){1'b0}}, 1'b1};
      end else if (start_i) begin
         cnt_q   <= '0;
         dwell_q <= load_i;
      end else if (tick_i) begin
         if (hit_o) begin
            cnt_q   <= '0;
            dwell_q <= load_i;
         end else begin
            cnt_q <= cnt_nxt[PW-1:0];
         end
      end
   end
endmodule

// File: rtl/bsw_sel_ctrl.sv
`timescale 1ns/1ps
module bsw_sel_ctrl
   import bsw_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vsync_i,
   input  logic [BSW_MODE_W-1:0] mode_i,
   input  logic                  sw_sel_i,
   input  logic                  hit_i,
   output logic                  start_o,
   output logic                  tick_o,
   output logic                  pick_b_o,
   output logic                  sel_o,
   output logic                  strobe_o
);
   logic       run_q;
   logic       sel_q;
   logic       sel_d;
   logic       strobe_q;
   logic       blink;
   bsw_event_e ev;

   always_comb begin
      blink = (mode_i == BSW_MODE_BLINK);
      if (!vsync_i)       ev = BSW_EV_NONE;
      else if (!blink)    ev = BSW_EV_SOFT;
      else if (!run_q)    ev = BSW_EV_ENTER;
      else                ev = BSW_EV_TICK;

      start_o  = (ev == BSW_EV_ENTER);
      tick_o   = (ev == BSW_EV_TICK);
      // the next dwell belongs to buffer 1 only when leaving buffer 0
      pick_b_o = tick_o && !sel_q;

      unique case (ev)
         BSW_EV_SOFT:  sel_d = sw_sel_i;
         BSW_EV_ENTER: sel_d = 1'b0;
         BSW_EV_TICK:  sel_d = hit_i ? ~sel_q : sel_q;
         default:      sel_d = sel_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         sel_q    <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         if (vsync_i) run_q <= blink;
         sel_q    <= sel_d;
         strobe_q <= (sel_d != sel_q);
      end
   end

   assign sel_o    = sel_q;
   assign strobe_o = strobe_q;
endmodule

// File: rtl/bsw_addr_out.sv
`timescale 1ns/1ps
module bsw_addr_out #(
   parameter int unsigned AW       = 32,
   parameter bit          ADDR_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_i,
   input  logic [AW-1:0] addr0_i,
   input  logic [AW-1:0] addr1_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] mux;
   assign mux = sel_i ? addr1_i : addr0_i;

   generate
      if (ADDR_REG) begin : g_reg
         logic [AW-1:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) addr_q <= '0;
            else        addr_q <= mux;
         end
         assign addr_o = addr_q;
      end else begin : g_comb
         assign addr_o = mux;
      end
   endgenerate
endmodule

// File: rtl/blink_buf_switch.sv
`timescale 1ns/1ps
module blink_buf_switch #(
   parameter int unsigned AW       = 32,
   parameter int unsigned PW       = 8,
   parameter bit          ADDR_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vsync_i,
   input  logic [1:0]    mode_i,
   input  logic [PW-1:0] per_a_i,
   input  logic [PW-1:0] per_b_i,
   input  logic          sw_sel_i,
   input  logic [AW-1:0] addr0_i,
   input  logic [AW-1:0] addr1_i,
   output logic [AW-1:0] start_addr_o,
   output logic          buf_sel_o,
   output logic          switch_o
);
   generate
      if (PW < 1 || PW > 16) begin : g_bad_pw
         $error("blink_buf_switch: PW must lie in 1..16");
      end
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("blink_buf_switch: AW must lie in 1..64");
      end
   endgenerate

   logic          start;
   logic          tick;
   logic          pick_b;
   logic          hit;
   logic [PW-1:0] dwell_load;

   bsw_sel_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .vsync_i  (vsync_i),
      .mode_i   (mode_i),
      .sw_sel_i (sw_sel_i),
      .hit_i    (hit),
      .start_o  (start),
      .tick_o   (tick),
      .pick_b_o (pick_b),
      .sel_o    (buf_sel_o),
      .strobe_o (switch_o)
   );

   bsw_period_sel #(.PW(PW)) u_per (
      .per_a_i  (per_a_i),
      .per_b_i  (per_b_i),
      .pick_b_i (pick_b),
      .dwell_o  (dwell_load)
   );

   bsw_dwell_counter #(.PW(PW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .tick_i  (tick),
      .load_i  (dwell_load),
      .hit_o   (hit)
   );

   bsw_addr_out #(.AW(AW), .ADDR_REG(ADDR_REG)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (buf_sel_o),
      .addr0_i (addr0_i),
      .addr1_i (addr1_i),
      .addr_o  (start_addr_o)
   );
endmodule

// File: rtl/blink_buf_switch_chk.sv
`timescale 1ns/1ps
module blink_buf_switch_chk #(
   parameter int unsigned AW       = 32,
   parameter bit          ADDR_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vsync_i,
   input logic [1:0]    mode_i,
   input logic          sw_sel_i,
   input logic [AW-1:0] addr0_i,
   input logic [AW-1:0] addr1_i,
   input logic [AW-1:0] start_addr_o,
   input logic          buf_sel_o,
   input logic          switch_o
);
   a_r3_sel_only_at_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_i |=> $stable(buf_sel_o));

   a_r2_soft_select: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync_i && mode_i != 2'b10) |=> (buf_sel_o == $past(sw_sel_i)));

   a_r8_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_sel_o != $past(buf_sel_o)) |-> switch_o);

   a_r8_strobe_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o |-> (buf_sel_o != $past(buf_sel_o)));

   a_r8_strobe_after_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o |-> $past(vsync_i));

   generate
      if (!ADDR_REG) begin : g_mux_chk
         a_r4_addr_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
            start_addr_o == (buf_sel_o ? addr1_i : addr0_i));
      end
   endgenerate
endmodule

bind blink_buf_switch blink_buf_switch_chk #(.AW(AW), .ADDR_REG(ADDR_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vsync_i      (vsync_i),
   .mode_i       (mode_i),
   .sw_sel_i     (sw_sel_i),
   .addr0_i      (addr0_i),
   .addr1_i      (addr1_i),
   .start_addr_o (start_addr_o),
   .buf_sel_o    (buf_sel_o),
   .switch_o     (switch_o)
);

// File: tb/blink_buf_switch_tb.sv
`timescale 1ns/1ps
module blink_buf_switch_tb;
   localparam int AW = 32;
   localparam int PW = 8;
   localparam int NV = 18;
   localparam logic [AW-1:0] ADR0 = 32'h1000_0000;
   localparam logic [AW-1:0] ADR1 = 32'h2000_0040;

   // {mode, per_a, per_b, sw_sel, expected sel, expected strobe}, one per vsync
   localparam logic [20:0] VEC [NV] = '{
      {2'b00, 8'd2, 8'd3, 1'b1, 1'b1, 1'b1},
      {2'b00, 8'd2, 8'd3, 1'b1, 1'b1, 1'b0},
      {2'b01, 8'd2, 8'd3, 1'b0, 1'b0, 1'b1},
      {2'b10, 8'd2, 8'd3, 1'b1, 1'b0, 1'b0},
      {2'b10, 8'd2, 8'd3, 1'b1, 1'b0, 1'b0},
      {2'b10, 8'd2, 8'd3, 1'b0, 1'b1, 1'b1},
      {2'b10, 8'd2, 8'd5, 1'b0, 1'b1, 1'b0},
      {2'b10, 8'd2, 8'd5, 1'b0, 1'b1, 1'b0},
      {2'b10, 8'd2, 8'd5, 1'b0, 1'b0, 1'b1},
      {2'b10, 8'd2, 8'd0, 1'b0, 1'b0, 1'b0},
      {2'b10, 8'd2, 8'd0, 1'b0, 1'b1, 1'b1},
      {2'b10, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
      {2'b10, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1},
      {2'b10, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
      {2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0},
      {2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 1'b1},
      {2'b10, 8'd1, 8'd1, 1'b1, 1'b0, 1'b1},
      {2'b10, 8'd1, 8'd1, 1'b1, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vsync_i = 1'b0;
   logic [1:0]    mode_i = 2'b00;
   logic [PW-1:0] per_a_i = '0;
   logic [PW-1:0] per_b_i = '0;
   logic          sw_sel_i = 1'b0;
   logic [AW-1:0] addr0_i = ADR0;
   logic [AW-1:0] addr1_i = ADR1;
   logic [AW-1:0] start_addr_o;
   logic          buf_sel_o;
   logic          switch_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   blink_buf_switch #(.AW(AW), .PW(PW)) u_dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse();
      @(negedge clk) vsync_i = 1'b1;
      @(negedge clk) vsync_i = 1'b0;
   endtask

   function automatic string req_of(input int i);
      if (i < 3)       return "R2";
      else if (i == 3) return "R5";
      else if (i < 6)  return "R6";
      else if (i < 9)  return "R9";
      else if (i < 14) return "R7";
      else if (i < 16) return "R10";
      else             return "R5";
   endfunction

   initial begin
      #500000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 sel", 64'(buf_sel_o), 64'd0);
      chk("R1 strobe", 64'(switch_o), 64'd0);
      chk("R1 addr", 64'(start_addr_o), 64'(ADR0));
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         {mode_i, per_a_i, per_b_i, sw_sel_i} = VEC[i][20:2];
         pulse();
         chk({req_of(i), " sel"}, 64'(buf_sel_o), 64'(VEC[i][1]));
         chk("R8 strobe", 64'(switch_o), 64'(VEC[i][0]));
         chk("R4 addr", 64'(start_addr_o), 64'(VEC[i][1] ? ADR1 : ADR0));
         @(negedge clk);
         chk("R8 strobe width", 64'(switch_o), 64'd0);
      end

      // R3: no change between pulses
      mode_i = 2'b00; sw_sel_i = 1'b0; per_a_i = 8'd7;
      repeat (4) @(negedge clk);
      chk("R3 sel held", 64'(buf_sel_o), 64'd1);
      chk("R3 no strobe", 64'(switch_o), 64'd0);
      chk("R4 addr1", 64'(start_addr_o), 64'(ADR1));

      // R10: leave blink at next pulse
      pulse();
      chk("R10 sel", 64'(buf_sel_o), 64'd0);
      chk("R10 strobe", 64'(switch_o), 64'd1);
      chk("R4 addr0", 64'(start_addr_o), 64'(ADR0));

      // R1: reset in the middle of operation
      sw_sel_i = 1'b1;
      pulse();
      chk("R2 sel", 64'(buf_sel_o), 64'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 sel after reset", 64'(buf_sel_o), 64'd0);
      chk("R1 addr after reset", 64'(start_addr_o), 64'(ADR0));
      chk("R1 strobe after reset", 64'(switch_o), 64'd0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule